// File: doc/BRIEF.md
# Content-Based Subsample Mask Generator

This block turns one 16x16 block of 8-bit luminance samples into a 256-bit pixel-selection mask for a power-scalable block-matching engine. Pixels stream in one per accepted cycle in raster order. The block first stores the whole block. It then runs a 3x3 high-pass filter over every position and records the largest and smallest gradient magnitude in the block.

A threshold is then placed between that minimum and maximum. The placement is set by a blend weight sampled with the block. Every pixel whose gradient reaches the threshold is treated as detail and is always selected. On top of that, a programmable 8x8 tile, repeated across the block, selects a regular background pattern. The union of both sets is the output mask, and the number of selected pixels is reported beside it. A host raises or lowers the blend weight and the tile density to trade matching quality against the number of active difference units.

Top module: `csm_mask_gen`

## Requirements
- R1: The gradient of pixel (r,c) is |8·P(r,c) − Σ of its eight neighbours|. A neighbour that falls outside the block takes the value of the nearest in-block pixel, which means the row and column are clamped to 0..15.
- R2: The threshold is (w·Gmax + (256 − w)·Gmin) >> 8, where Gmax and Gmin are the extreme gradients of the block. w equals blend_m1, except that blend_m1 = 255 gives w = 256, so the threshold equals Gmax. blend_m1 = 0 gives a threshold of Gmin.
- R3: A pixel is an edge pixel when its gradient is greater than or equal to the threshold, so ties count as edges.
- R4: csm_mask bit r·16+c is the OR of the edge flag of pixel (r,c) and tile_mask bit (r mod 8)·8 + (c mod 8).
- R5: csm_count equals the number of ones in csm_mask.
- R6: csm_valid rises with the 513th rising edge after the edge that accepts the 256th pixel. done is high for exactly the one cycle that follows. The mask and the count then hold until the next block starts.
- R7: A cycle with pix_valid low stores nothing. pix_valid pulses that arrive while a block is still being processed are ignored and do not shift the next block.
- R8: After reset, csm_valid and done are low and csm_count is 0.
- R9: blend_m1 and tile_mask are sampled on the edge that accepts the 256th pixel. Later changes to them do not affect that block's result.
- R10: csm_valid drops on the edge that accepts the first pixel of the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | pix_data carries the next raster pixel |
| pix_data | input | 8 | Luminance sample |
| blend_m1 | input | 8 | Unsigned Q0.8 threshold blend weight |
| tile_mask | input | 64 | Regular 8x8 selection tile, bit (row·8+col) |
| csm_mask | output | 256 | Final selection mask, bit (row·16+col) |
| csm_count | output | 9 | Population count of csm_mask |
| csm_valid | output | 1 | Mask and count are final |
| done | output | 1 | One-cycle pulse the cycle after csm_valid rises |

## Verification
The last pixel is accepted on one edge. From there, the gradient pass takes 256 edges, the threshold takes one, and the marking pass takes 256, so csm_valid is due on the 513th edge and done on the 514th. The bench counts falling edges from the one that follows the accepting edge, so that the count equals the number of rising edges passed. It requires csm_valid to appear on exactly the 513th, and it samples done on the next two falling edges. Mask and count are compared against a model in the bench only once csm_valid has been seen, and always half a cycle away from the active edge.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_GRAD,
    ST_THR,
    ST_MARK,
    ST_FIN
  } csm_state_e;
endpackage

// File: rtl/csm_pixel_store.sv
module csm_pixel_store #(
  parameter int BLK  = 16,
  parameter int PIXW = 8,
  localparam int NPIX = BLK * BLK,
  localparam int AW   = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [PIXW-1:0]   wdata,
  input  logic [AW-1:0]     cidx,
  output logic [9*PIXW-1:0] win
);
  logic [PIXW-1:0] pix_q [NPIX];

  always_ff @(posedge clk) begin
    if (we) pix_q[waddr] <= wdata;
  end

  // 3x3 window around cidx, edges replicated by clamping row/col
  always_comb begin
    int row, col, rr, cc;
    row = int'(cidx) / BLK;
    col = int'(cidx) % BLK;
    for (int k = 0; k < 9; k++) begin
      rr = row + (k / 3) - 1;
      cc = col + (k % 3) - 1;
      if (rr < 0) rr = 0;
      if (rr > BLK - 1) rr = BLK - 1;
      if (cc < 0) cc = 0;
      if (cc > BLK - 1) cc = BLK - 1;
      win[k*PIXW +: PIXW] = pix_q[AW'(rr * BLK + cc)];
    end
  end
endmodule

// File: rtl/csm_hpf_grad.sv
module csm_hpf_grad #(
  parameter int PIXW = 8,
  localparam int GW = PIXW + 3
) (
  input  logic [9*PIXW-1:0] win,
  output logic [GW-1:0]     grad
);
  logic [GW-1:0] nsum;
  logic [GW-1:0] ctr8;

  always_comb begin
    nsum = '0;
    for (int k = 0; k < 9; k++) begin
      if (k != 4) nsum = nsum + GW'(win[k*PIXW +: PIXW]);
    end
    ctr8 = GW'(win[4*PIXW +: PIXW]) << 3;
    grad = (ctr8 >= nsum) ? (ctr8 - nsum) : (nsum - ctr8);
  end
endmodule

// File: rtl/csm_grad_ram.sv
module csm_grad_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/csm_mask_gen.sv
module csm_mask_gen
  import csm_pkg::*;
#(
  parameter int BLK  = 16,
  parameter int PIXW = 8,
  parameter int M1W  = 8,
  parameter int TILE = 8,
  localparam int NPIX  = BLK * BLK,
  localparam int AW    = $clog2(NPIX),
  localparam int GW    = PIXW + 3,
  localparam int CNTW  = $clog2(NPIX + 1),
  localparam int TBITS = TILE * TILE,
  localparam int TIW   = $clog2(TBITS),
  localparam int PW    = GW + M1W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [PIXW-1:0]  pix_data,
  input  logic [M1W-1:0]   blend_m1,
  input  logic [TBITS-1:0] tile_mask,
  output logic [NPIX-1:0]  csm_mask,
  output logic [CNTW-1:0]  csm_count,
  output logic             csm_valid,
  output logic             done
);
  csm_state_e       state_q;
  logic [AW-1:0]    idx_q;
  logic [GW-1:0]    gmax_q, gmin_q, thr_q;
  logic [M1W-1:0]   m1_q;
  logic [TBITS-1:0] tile_q;
  logic [NPIX-1:0]  mask_q;
  logic [CNTW-1:0]  cnt_q;
  logic             valid_q, done_q;
  logic             mark_phase;

  logic [9*PIXW-1:0] win;
  logic [GW-1:0]     grad, grad_rd;
  logic [AW-1:0]     raddr;
  logic              tile_bit, sel_bit;
  logic [PW-1:0]     wgt, blend_sum;
  logic              last_idx;

  assign last_idx   = (idx_q == AW'(NPIX - 1));
  assign mark_phase = (state_q == ST_MARK);

  csm_pixel_store #(.BLK(BLK), .PIXW(PIXW)) store_i (
    .clk(clk), .we((state_q == ST_LOAD) && pix_valid), .waddr(idx_q),
    .wdata(pix_data), .cidx(idx_q), .win(win)
  );

  csm_hpf_grad #(.PIXW(PIXW)) grad_i (.win(win), .grad(grad));

  assign raddr = mark_phase ? idx_q + AW'(1) : '0;

  csm_grad_ram #(.DEPTH(NPIX), .W(GW)) gram_i (
    .clk(clk), .we(state_q == ST_GRAD), .waddr(idx_q), .wdata(grad),
    .raddr(raddr), .rdata(grad_rd)
  );

  always_comb begin
    int trow, tcol;
    trow     = int'(idx_q) / BLK;
    tcol     = int'(idx_q) % BLK;
    tile_bit = tile_q[TIW'((trow % TILE) * TILE + (tcol % TILE))];
    sel_bit  = tile_bit | (grad_rd >= thr_q);
  end

  // full-scale code maps to weight 2^M1W
  always_comb begin
    wgt = (m1_q == '1) ? PW'(1) << M1W : PW'(m1_q);
    blend_sum = wgt * PW'(gmax_q) + ((PW'(1) << M1W) - wgt) * PW'(gmin_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
      gmax_q  <= '0;
      gmin_q  <= '1;
      thr_q   <= '0;
      m1_q    <= '0;
      tile_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_LOAD: if (pix_valid) begin
          idx_q <= idx_q + AW'(1);
          if (idx_q == '0) valid_q <= 1'b0;
          if (last_idx) begin
            state_q <= ST_GRAD;
            m1_q    <= blend_m1;
            tile_q  <= tile_mask;
            gmax_q  <= '0;
            gmin_q  <= '1;
          end
        end
        ST_GRAD: begin
          if (grad > gmax_q) gmax_q <= grad;
          if (grad < gmin_q) gmin_q <= grad;
          idx_q <= idx_q + AW'(1);
          if (last_idx) state_q <= ST_THR;
        end
        ST_THR: begin
          thr_q   <= GW'(blend_sum >> M1W);
          mask_q  <= '0;
          cnt_q   <= '0;
          state_q <= ST_MARK;
        end
        ST_MARK: begin
          mask_q[idx_q] <= sel_bit;
          cnt_q <= cnt_q + CNTW'(sel_bit);
          idx_q <= idx_q + AW'(1);
          if (last_idx) begin
            state_q <= ST_FIN;
            valid_q <= 1'b1;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_LOAD;
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign csm_mask  = mask_q;
  assign csm_count = cnt_q;
  assign csm_valid = valid_q;
  assign done      = done_q;
endmodule

// File: rtl/csm_mask_gen_chk.sv
module csm_mask_gen_chk #(
  parameter int BLK  = 16,
  parameter int TILE = 8,
  parameter int GW   = 11,
  localparam int NPIX  = BLK * BLK,
  localparam int CNTW  = $clog2(NPIX + 1),
  localparam int TBITS = TILE * TILE
) (
  input logic             clk,
  input logic             rst,
  input logic             csm_valid,
  input logic             done,
  input logic [NPIX-1:0]  csm_mask,
  input logic [CNTW-1:0]  csm_count,
  input logic [TBITS-1:0] tile_q,
  input logic [GW-1:0]    thr_q,
  input logic [GW-1:0]    gmax_q,
  input logic [GW-1:0]    gmin_q,
  input logic             mark_phase
);
  logic [NPIX-1:0] tile_full;

  for (genvar i = 0; i < NPIX; i++) begin : g_tile
    assign tile_full[i] = tile_q[((i / BLK) % TILE) * TILE + ((i % BLK) % TILE)];
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    csm_valid |-> (csm_count == CNTW'($countones(csm_mask)))); // R5
  AST_TILE_FORCED: assert property (@(posedge clk) disable iff (rst)
    csm_valid |-> ((csm_mask & tile_full) == tile_full)); // R4
  AST_THR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mark_phase |-> (thr_q >= gmin_q && thr_q <= gmax_q)); // R2
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(csm_valid) |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (csm_valid && $past(csm_valid)) |-> ($stable(csm_mask) && $stable(csm_count))); // R6
endmodule

bind csm_mask_gen csm_mask_gen_chk #(.BLK(BLK), .TILE(TILE), .GW(GW)) chk_i (
  .clk(clk), .rst(rst), .csm_valid(csm_valid), .done(done),
  .csm_mask(csm_mask), .csm_count(csm_count), .tile_q(tile_q),
  .thr_q(thr_q), .gmax_q(gmax_q), .gmin_q(gmin_q), .mark_phase(mark_phase)
);

// File: tb/csm_mask_gen_tb.sv
module csm_mask_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pix_valid = 1'b0;
  logic [7:0]   pix_data = '0;
  logic [7:0]   blend_m1 = '0;
  logic [63:0]  tile_mask = '0;
  logic [255:0] csm_mask;
  logic [8:0]   csm_count;
  logic         csm_valid, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [7:0]   px [256];
  logic [255:0] exp_mask;
  int           exp_cnt;

  always #4 clk = ~clk;

  csm_mask_gen dut_i (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .blend_m1(blend_m1), .tile_mask(tile_mask), .csm_mask(csm_mask),
    .csm_count(csm_count), .csm_valid(csm_valid), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  // kind, seed, m1, tile
  localparam logic [83:0] VECS [0:6] = '{
    {4'd0, 8'd90,  8'd128, 64'h0},
    {4'd1, 8'd3,   8'd128, 64'h00000000000000FF},
    {4'd2, 8'd40,  8'd64,  64'h0101010101010101},
    {4'd3, 8'd7,   8'd200, 64'h8844221188442211},
    {4'd4, 8'd119, 8'd255, 64'h0},
    {4'd5, 8'd0,   8'd0,   64'h0},
    {4'd3, 8'd3,   8'd254, 64'hAAAAAAAAAAAAAAAA}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pgen(int kind, int seed, int i);
    int r, c;
    r = i / 16;
    c = i % 16;
    case (kind)
      0: return 8'(seed);
      1: return 8'(c * seed + r * 5);
      2: return ((r + c) % 2 == 1) ? 8'(seed) : 8'd0;
      3: return 8'((i * i * 7 + seed * 13 + i * 29) & 255);
      4: return (i == seed) ? 8'd255 : 8'd0;
      default: return (c >= 8) ? 8'd200 : 8'd10;
    endcase
  endfunction

  // model from R1..R5
  task automatic ref_calc(input int m1, input logic [63:0] tile);
    int g [256];
    int gmax, gmin, w, thr;
    gmax = 0;
    gmin = 1 << 30;
    for (int i = 0; i < 256; i++) begin
      int r, c, s;
      r = i / 16;
      c = i % 16;
      s = 0;
      for (int dr = -1; dr <= 1; dr++) begin
        for (int dc = -1; dc <= 1; dc++) begin
          int rr, cc;
          rr = r + dr;
          cc = c + dc;
          if (rr < 0) rr = 0;
          if (rr > 15) rr = 15;
          if (cc < 0) cc = 0;
          if (cc > 15) cc = 15;
          if (dr != 0 || dc != 0) s = s + int'(px[rr * 16 + cc]);
        end
      end
      g[i] = 8 * int'(px[i]) - s;
      if (g[i] < 0) g[i] = -g[i];
      if (g[i] > gmax) gmax = g[i];
      if (g[i] < gmin) gmin = g[i];
    end
    w = (m1 == 255) ? 256 : m1;
    thr = (w * gmax + (256 - w) * gmin) / 256;
    exp_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      exp_mask[i] = tile[((i / 16) % 8) * 8 + ((i % 16) % 8)] | (g[i] >= thr);
      if (exp_mask[i]) exp_cnt = exp_cnt + 1;
    end
  endtask

  task automatic send_block(input int kind, input int seed, input int m1,
                            input logic [63:0] tile, input bit gaps);
    for (int i = 0; i < 256; i++) px[i] = pgen(kind, seed, i);
    ref_calc(m1, tile);
    blend_m1  = 8'(m1);
    tile_mask = tile;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = px[i];
      if (gaps && i < 255) begin
        @(negedge clk);
        pix_valid = 1'b0;
        pix_data  = 8'hEE; // R7 junk in an idle cycle
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic wait_check(input string tag, input bit disturb);
    int j;
    j = 0;
    while (1) begin
      @(negedge clk);
      j++;
      if (disturb && j == 5) begin
        pix_valid = 1'b1;
        pix_data  = 8'h77;
        blend_m1  = ~blend_m1;  // R9 late change
        tile_mask = ~tile_mask;
      end
      if (disturb && j == 31) pix_valid = 1'b0; // R7 ignored pulses end
      if (csm_valid || j > 2000) break;
    end
    check(j == 513, "R6", {tag, " latency"}, 256'(j), 256'd513);
    check(csm_mask == exp_mask, "R4", {tag, " mask"}, csm_mask, exp_mask);
    check(int'(csm_count) == exp_cnt, "R5", {tag, " count"}, 256'(csm_count), 256'(exp_cnt));
    @(negedge clk);
    check(done == 1'b1, "R6", {tag, " done high"}, 256'(done), 256'd1);
    @(negedge clk);
    check(done == 1'b0 && csm_valid == 1'b1, "R6", {tag, " done pulse/hold"},
          256'({done, csm_valid}), 256'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(csm_valid == 1'b0 && done == 1'b0 && csm_count == '0, "R8", "reset outputs",
          256'({csm_valid, done, csm_count}), 256'd0);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 7; v++) begin
      logic [83:0] e;
      e = VECS[v];
      send_block(int'(e[83:80]), int'(e[79:72]), int'(e[71:64]), e[63:0], 1'b0);
      wait_check($sformatf("R1 R3 vec%0d", v), 1'b0);
    end

    // R2 full scale: single spike, only the spike survives
    send_block(4, 37, 255, 64'h0, 1'b0);
    wait_check("R2 full-scale", 1'b0);
    check(csm_count == 9'd1 && csm_mask[37], "R2", "full-scale spike only",
          256'(csm_count), 256'd1);

    // R3 flat block: all gradients equal the threshold -> all edges
    send_block(0, 200, 77, 64'h0, 1'b0);
    wait_check("R3 ties", 1'b0);
    check(csm_count == 9'd256, "R3", "ties are edges", 256'(csm_count), 256'd256);

    // R7 gaps with junk between pixels
    send_block(3, 11, 150, 64'h0F0F0F0F0F0F0F0F, 1'b1);
    wait_check("R7 gaps", 1'b0);

    // R7 R9 pulses and input changes during processing
    send_block(2, 90, 100, 64'h8000000000000001, 1'b0);
    wait_check("R7 R9 disturb", 1'b1);

    // R7 next block must start at pixel 0 after ignored pulses; R10 valid drop
    for (int i = 0; i < 256; i++) px[i] = pgen(1, 6, i);
    ref_calc(30, 64'h3);
    blend_m1  = 8'd30;
    tile_mask = 64'h3;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = px[0];
    @(negedge clk);
    check(csm_valid == 1'b0, "R10", "valid drops on first pixel", 256'(csm_valid), 256'd0);
    for (int i = 1; i < 256; i++) begin
      pix_data = px[i];
      @(negedge clk);
    end
    pix_valid = 1'b0;
    wait_check("R7 R10 restart", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule